// File: doc/BRIEF.md
# Miscellaneous-Operation Execution Unit

This unit executes one group of 32-bit three-register instructions in a single pipeline stage. It takes a 4-bit operation selector, the destination and third-operand register fields, and the two source operand values that the register file has already read. From these it produces a registered result, a destination write-enable, the destination index, and two flags. The illegal-instruction flag reports an operation that needs an option the core was built without. The not-handled flag tells a neighbouring decoder that this unit does not own the encoding.

The operations are sign extension and signed clamp, where the bit position comes from the third-operand field. There are also signed and unsigned minimum and maximum, and four conditional moves that test the third operand against zero. The conditional moves can suppress the register write entirely. An issue strobe qualifies each instruction. Every output updates on the clock edge that follows the issue.

Top module: `misc_exec_unit`

## Requirements
- R1: Outputs are registered. An instruction presented with issueValid high is reflected on result, wrEn, dstIdx, illegal and notHandled after the next rising clock edge. A cycle without issueValid gives wrEn, illegal and notHandled all low.
- R2: op2 = 2 (sign extend) treats bit p = tIdx+7 of srcS as the sign and copies it into bits 31 down to p+1. tIdx=0 gives a byte extension and tIdx=8 a halfword extension.
- R3: op2 = 3 (signed clamp) writes srcS unchanged when bits 31 down to p (p = tIdx+7) of srcS are all equal.
- R4: When the signed clamp saturates, a non-negative srcS gives 2^p−1 and a negative srcS gives −2^p.
- R5: op2 = 4 writes srcS if signed srcS ≤ srcT, otherwise srcT. op2 = 5 writes srcS if signed srcS ≥ srcT, otherwise srcT.
- R6: op2 = 6 and op2 = 7 are the unsigned forms of op2 = 4 and op2 = 5.
- R7: Conditional moves write srcS with wrEn high when their test on srcT holds. op2 = 8 tests srcT == 0, op2 = 9 tests srcT != 0, op2 = 10 tests srcT bit 31 set, and op2 = 11 tests srcT bit 31 clear.
- R8: A conditional move whose test fails gives wrEn low and illegal low.
- R9: With miscOptEn low, op2 from 2 to 7 gives illegal high and wrEn low. The conditional moves behave the same whatever miscOptEn is.
- R10: op2 values 0, 1 and 12 to 15 give notHandled high, with wrEn and illegal low.
- R11: dstIdx equals the rIdx of the instruction, and every valid write (op2 2 to 7 with the option, or a move that passes its test) gives wrEn high.
- R12: While rstN is low, result is zero and wrEn, illegal and notHandled are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is presented this cycle |
| op2 | input | 4 | Operation selector |
| rIdx | input | 4 | Destination register field |
| tIdx | input | 4 | Third-operand field, also the bit-position immediate |
| srcS | input | 32 | Operand read at the s field |
| srcT | input | 32 | Operand read at the t field |
| miscOptEn | input | 1 | Miscellaneous-operation option is configured |
| result | output | 32 | Value to write to the destination |
| wrEn | output | 1 | Destination write-enable |
| dstIdx | output | 4 | Destination register index |
| illegal | output | 1 | Illegal-instruction flag |
| notHandled | output | 1 | Encoding belongs to another unit |

## Verification
Two decisions can meet in one issue cycle. The first is the option gate, which turns an arithmetic operation into an illegal instruction. The second is the conditional-move test, which withholds the write. Random stimulus mixes all sixteen op2 values with miscOptEn mostly high but sometimes low, back to back. The bench then judges wrEn, illegal and notHandled together against a reference function, so a gate that leaks into a move, or a test that leaks into an arithmetic operation, shows up as a flag mismatch. Directed cases add the clamp edges at exactly ±2^(tIdx+7) for tIdx of 0, 8 and 15, and equal operands for minimum and maximum.

// File: rtl/misc_exec_pkg.sv
package misc_exec_pkg;

  typedef enum logic [3:0] {
    OP_SEXT   = 4'd2,
    OP_CLAMP  = 4'd3,
    OP_MIN    = 4'd4,
    OP_MAX    = 4'd5,
    OP_MINU   = 4'd6,
    OP_MAXU   = 4'd7,
    OP_MOVEQZ = 4'd8,
    OP_MOVNEZ = 4'd9,
    OP_MOVLTZ = 4'd10,
    OP_MOVGEZ = 4'd11
  } miscOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       selSext;
    logic       selClamp;
    logic       selMinMax;
    logic       cmpUnsigned;
    logic       pickMax;
    logic       selMove;
    logic [1:0] moveKind;   // 0 eq zero, 1 not zero, 2 negative, 3 non-negative
    logic       writeReq;   // unconditional write
    logic       illegal;
    logic       notHandled;
  } miscCtrl_t;

endpackage

// File: rtl/misc_exec_ctrl.sv
module misc_exec_ctrl
  import misc_exec_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op2,
  input  logic            miscOptEn,
  output miscCtrl_t       ctrl
);

  always_comb begin
    ctrl = '0;
    case (op2)
      OP_SEXT, OP_CLAMP, OP_MIN, OP_MAX, OP_MINU, OP_MAXU: begin
        if (miscOptEn) begin
          ctrl.writeReq    = 1'b1;
          ctrl.selSext     = (op2 == OP_SEXT);
          ctrl.selClamp    = (op2 == OP_CLAMP);
          ctrl.selMinMax   = (op2 >= OP_MIN);
          ctrl.cmpUnsigned = (op2 == OP_MINU) || (op2 == OP_MAXU);
          ctrl.pickMax     = (op2 == OP_MAX) || (op2 == OP_MAXU);
        end else begin
          ctrl.illegal = 1'b1;
        end
      end
      OP_MOVEQZ, OP_MOVNEZ, OP_MOVLTZ, OP_MOVGEZ: begin
        ctrl.selMove  = 1'b1;
        ctrl.moveKind = op2[1:0];
      end
      default: ctrl.notHandled = 1'b1;
    endcase
  end

endmodule

// File: rtl/misc_exec_dp.sv
module misc_exec_dp
  import misc_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 4,
  parameter int POS_OFS = 7
) (
  input  miscCtrl_t          ctrl,
  input  logic [FIELD_W-1:0] tField,
  input  logic [DATA_W-1:0]  srcS,
  input  logic [DATA_W-1:0]  srcT,
  output logic [DATA_W-1:0]  resultNext,
  output logic               moveTaken
);

  localparam int POS_W = $clog2(DATA_W);

  logic [POS_W-1:0]  signPos;
  logic [DATA_W-1:0] sextVal;
  logic [DATA_W-1:0] hiMask;
  logic [DATA_W-1:0] fillWord;
  logic [DATA_W-1:0] clampVal;
  logic              clampFits;
  logic              sLe, sGe, uLe, uGe, keepS;
  logic [DATA_W-1:0] minMaxVal;

  assign signPos = POS_W'(tField) + POS_W'(POS_OFS);

  // Sign extension: bits above signPos take the sign bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_sext
    assign sextVal[i] = ((POS_W+1)'(i) > {1'b0, signPos}) ? srcS[signPos] : srcS[i];
  end

  // Signed clamp
  assign hiMask    = {DATA_W{1'b1}} << signPos;
  assign fillWord  = {DATA_W{srcS[DATA_W-1]}};
  assign clampFits = ((srcS ^ fillWord) & hiMask) == '0;
  assign clampVal  = clampFits ? srcS : (fillWord ^ ~hiMask);

  // Min / max
  assign sLe = $signed(srcS) <= $signed(srcT);
  assign sGe = $signed(srcS) >= $signed(srcT);
  assign uLe = srcS <= srcT;
  assign uGe = srcS >= srcT;

  always_comb begin
    if (ctrl.cmpUnsigned) keepS = ctrl.pickMax ? uGe : uLe;
    else                  keepS = ctrl.pickMax ? sGe : sLe;
  end
  assign minMaxVal = keepS ? srcS : srcT;

  // Conditional move test
  always_comb begin
    case (ctrl.moveKind)
      2'd0:    moveTaken = ctrl.selMove && (srcT == '0);
      2'd1:    moveTaken = ctrl.selMove && (srcT != '0);
      2'd2:    moveTaken = ctrl.selMove && srcT[DATA_W-1];
      default: moveTaken = ctrl.selMove && !srcT[DATA_W-1];
    endcase
  end

  always_comb begin
    if (ctrl.selSext)        resultNext = sextVal;
    else if (ctrl.selClamp)  resultNext = clampVal;
    else if (ctrl.selMinMax) resultNext = minMaxVal;
    else if (ctrl.selMove)   resultNext = srcS;
    else                     resultNext = '0;
  end

endmodule

// File: rtl/misc_exec_unit.sv
module misc_exec_unit
  import misc_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 4,
  parameter int OP_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [OP_W-1:0]    op2,
  input  logic [FIELD_W-1:0] rIdx,
  input  logic [FIELD_W-1:0] tIdx,
  input  logic [DATA_W-1:0]  srcS,
  input  logic [DATA_W-1:0]  srcT,
  input  logic               miscOptEn,
  output logic [DATA_W-1:0]  result,
  output logic               wrEn,
  output logic [FIELD_W-1:0] dstIdx,
  output logic               illegal,
  output logic               notHandled
);

  miscCtrl_t         ctrl;
  logic [DATA_W-1:0] resultNext;
  logic              moveTaken;

  misc_exec_ctrl #(.OP_W(OP_W)) u_ctrl (
    .op2       (op2),
    .miscOptEn (miscOptEn),
    .ctrl      (ctrl)
  );

  misc_exec_dp #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_dp (
    .ctrl       (ctrl),
    .tField     (tIdx),
    .srcS       (srcS),
    .srcT       (srcT),
    .resultNext (resultNext),
    .moveTaken  (moveTaken)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result     <= '0;
      wrEn       <= 1'b0;
      dstIdx     <= '0;
      illegal    <= 1'b0;
      notHandled <= 1'b0;
    end else begin
      result     <= resultNext;
      dstIdx     <= rIdx;
      wrEn       <= issueValid && (ctrl.writeReq || moveTaken);
      illegal    <= issueValid && ctrl.illegal;
      notHandled <= issueValid && ctrl.notHandled;
    end
  end

endmodule

// File: rtl/misc_exec_chk.sv
module misc_exec_chk #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 4,
  parameter int OP_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               issueValid,
  input logic [OP_W-1:0]    op2,
  input logic [FIELD_W-1:0] rIdx,
  input logic [DATA_W-1:0]  srcS,
  input logic [DATA_W-1:0]  srcT,
  input logic               miscOptEn,
  input logic [DATA_W-1:0]  result,
  input logic               wrEn,
  input logic [FIELD_W-1:0] dstIdx,
  input logic               illegal,
  input logic               notHandled
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!wrEn && !illegal && !notHandled));

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({wrEn, illegal, notHandled}) <= 1);

  p_move_false_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && op2 == 4'd8 && srcT != '0) |=> (!wrEn && !illegal));

  p_gate_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !miscOptEn && op2 >= 4'd2 && op2 <= 4'd7) |=> (illegal && !wrEn));

  p_umin_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && miscOptEn && op2 == 4'd6) |=>
      (wrEn && result == (($past(srcS) <= $past(srcT)) ? $past(srcS) : $past(srcT))));

  p_dst_follow_r11: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> (dstIdx == $past(rIdx)));

endmodule

bind misc_exec_unit misc_exec_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .OP_W(OP_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .op2        (op2),
  .rIdx       (rIdx),
  .srcS       (srcS),
  .srcT       (srcT),
  .miscOptEn  (miscOptEn),
  .result     (result),
  .wrEn       (wrEn),
  .dstIdx     (dstIdx),
  .illegal    (illegal),
  .notHandled (notHandled)
);

// File: tb/misc_exec_unit_tb.sv
module misc_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [3:0]  op2 = '0;
  logic [3:0]  rIdx = '0;
  logic [3:0]  tIdx = '0;
  logic [31:0] srcS = '0;
  logic [31:0] srcT = '0;
  logic        miscOptEn = 1'b1;
  logic [31:0] result;
  logic        wrEn;
  logic [3:0]  dstIdx;
  logic        illegal;
  logic        notHandled;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  misc_exec_unit u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .op2(op2), .rIdx(rIdx),
    .tIdx(tIdx), .srcS(srcS), .srcT(srcT), .miscOptEn(miscOptEn),
    .result(result), .wrEn(wrEn), .dstIdx(dstIdx), .illegal(illegal),
    .notHandled(notHandled)
  );

  function automatic string reqOf(input logic [3:0] op, input logic opt);
    if ((op >= 4'd2 && op <= 4'd7) && !opt) return "R9";
    case (op)
      4'd2: return "R2";
      4'd3: return "R3/R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9, 4'd10, 4'd11: return "R7/R8";
      default: return "R10";
    endcase
  endfunction

  task automatic refModel(input logic [3:0] op, input logic [3:0] t, input logic [31:0] s,
                          input logic [31:0] tv, input logic opt,
                          output logic [31:0] res, output logic we, output logic ill,
                          output logic nh);
    int p;
    int sh;
    longint sv;
    longint hi;
    longint lo;
    p = int'(t) + 7;
    sh = 31 - p;
    res = '0; we = 0; ill = 0; nh = 0;
    if (op >= 4'd2 && op <= 4'd7 && !opt) begin
      ill = 1;
    end else begin
      case (op)
        4'd2: begin we = 1; res = 32'($signed(s << sh) >>> sh); end
        4'd3: begin
          we = 1;
          sv = longint'($signed(s));
          hi = (64'sd1 <<< p) - 1;
          lo = -(64'sd1 <<< p);
          if (sv > hi) res = 32'(hi);
          else if (sv < lo) res = 32'(lo);
          else res = s;
        end
        4'd4: begin we = 1; res = ($signed(s) <= $signed(tv)) ? s : tv; end
        4'd5: begin we = 1; res = ($signed(s) >= $signed(tv)) ? s : tv; end
        4'd6: begin we = 1; res = (s <= tv) ? s : tv; end
        4'd7: begin we = 1; res = (s >= tv) ? s : tv; end
        4'd8:  begin we = (tv == 0);              res = s; end
        4'd9:  begin we = (tv != 0);              res = s; end
        4'd10: begin we = ($signed(tv) < 0);      res = s; end
        4'd11: begin we = ($signed(tv) >= 0);     res = s; end
        default: nh = 1;
      endcase
    end
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic runOp(input logic [3:0] op, input logic [3:0] r, input logic [3:0] t,
                       input logic [31:0] s, input logic [31:0] tv, input logic opt);
    logic [31:0] eRes;
    logic eWe, eIll, eNh;
    string req;
    refModel(op, t, s, tv, opt, eRes, eWe, eIll, eNh);
    req = reqOf(op, opt);
    issueValid = 1; op2 = op; rIdx = r; tIdx = t; srcS = s; srcT = tv; miscOptEn = opt;
    @(negedge clk);
    check(req, "wrEn", 32'(wrEn), 32'(eWe));
    check(req, "illegal", 32'(illegal), 32'(eIll));
    check(req, "notHandled", 32'(notHandled), 32'(eNh));
    if (eWe) begin
      check(req, "result", result, eRes);
      check("R11", "dstIdx", 32'(dstIdx), 32'(r));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "result", result, 0);
    check("R12", "wrEn", 32'(wrEn), 0);
    check("R12", "illegal", 32'(illegal), 0);
    check("R12", "notHandled", 32'(notHandled), 0);
    rstN = 1;
    @(negedge clk);

    // R2 sign extension at t = 0, 8, 15
    runOp(4'd2, 4'd1, 4'd0,  32'h0000_0080, 0, 1);
    runOp(4'd2, 4'd2, 4'd0,  32'hFFFF_FF7F, 0, 1);
    runOp(4'd2, 4'd3, 4'd8,  32'h1234_8001, 0, 1);
    runOp(4'd2, 4'd4, 4'd15, 32'h0040_0000, 0, 1);
    // R3 and R4 clamp boundaries at exactly +/-2^(t+7)
    foreach (tList[k]) begin
      int p;
      p = int'(tList[k]) + 7;
      runOp(4'd3, 4'd5, tList[k], (32'd1 << p) - 1, 0, 1);       // R3 fits
      runOp(4'd3, 4'd5, tList[k], 32'd1 << p, 0, 1);             // R4 saturates high
      runOp(4'd3, 4'd5, tList[k], -(32'd1 << p), 0, 1);          // R3 fits
      runOp(4'd3, 4'd5, tList[k], -(32'd1 << p) - 1, 0, 1);      // R4 saturates low
    end
    // R5 R6 equal operands and sign-sensitive pairs
    for (int op = 4; op <= 7; op++) begin
      runOp(4'(op), 4'd6, 4'd0, 32'h8000_0000, 32'h8000_0000, 1);
      runOp(4'(op), 4'd7, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1);
    end
    // R7 R8 moves at zero and sign boundaries
    for (int op = 8; op <= 11; op++) begin
      runOp(4'(op), 4'd9, 4'd3, 32'hCAFE_0000 + 32'(op), 32'h0, 0);
      runOp(4'(op), 4'd9, 4'd3, 32'hBEEF_0000 + 32'(op), 32'h8000_0000, 1);
      runOp(4'(op), 4'd9, 4'd3, 32'hF00D_0000 + 32'(op), 32'h7FFF_FFFF, 1);
    end
    // R9 option absent, R10 foreign encodings
    runOp(4'd4, 4'd2, 4'd0, 32'h1, 32'h2, 0);
    runOp(4'd0, 4'd2, 4'd0, 32'h1, 32'h2, 1);
    runOp(4'd15, 4'd2, 4'd0, 32'h1, 32'h2, 1);
    // R1 idle cycle after an issue
    issueValid = 0;
    @(negedge clk);
    check("R1", "wrEn idle", 32'(wrEn), 0);
    check("R1", "notHandled idle", 32'(notHandled), 0);

    // Random back-to-back mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] s;
      logic [31:0] tv;
      logic [3:0] t;
      t = 4'($urandom);
      s = $urandom;
      tv = $urandom;
      case ($urandom % 4)
        0: s = 32'($signed(s) >>> (8 + ($urandom % 20)));
        1: tv = ($urandom % 2) ? 32'h0 : s;
        default: ;
      endcase
      runOp(4'($urandom), 4'($urandom), t, s, tv, ($urandom % 8) != 0);
      if ($urandom % 16 == 0) begin
        issueValid = 0;
        @(negedge clk);
        check("R1", "wrEn idle", 32'(wrEn), 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [3:0] tList [3] = '{4'd0, 4'd8, 4'd15};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule